// File: doc/BRIEF.md
# Module Clock Gate Register Bank

This block holds the on/off state of a set of module clocks behind a small 32-bit register bus. The clocks are grouped sixteen to a register, so a module with linear number `g*16 + b` is controlled by bit `b` of enable register `g`. Every write carries its own change mask in the upper half-word. Software can therefore switch a single clock without reading the register first, and two agents that touch different bits of the same register cannot overwrite each other's settings.

For each enable register there is a matching status register. It reports whether each clock is actually running. The physical clock cells are not part of this block: each module clock is represented by an enable output. The status path models the gate's settling time with a synchroniser chain of configurable length. Software turns a clock on, then polls the status bit until it reads 1 before using the module. A reset parameter lets chosen clocks, such as those needed to boot, come out of reset already enabled.

Top module: `clk_gate_bank`

## Requirements
- R1: Enable register `g` (0 <= g < NUM_REGS) is decoded at byte offset EN_BASE + 4*g (default EN_BASE = 0x600). Status register `g` is decoded at MON_BASE + 4*g (default MON_BASE = 0x800). Bit `b` of either register belongs to module clock `g*16 + b`, which drives output `clk_en[g*16 + b]`.
- R2: In a write to an enable register, bit `b+16` of the write data is the change mask for bit `b`. A bit whose mask is 0 keeps its value, whatever the data bit holds.
- R3: A bit whose mask is 1 takes the data bit: 1 switches that module clock on, 0 switches it off.
- R4: A read of an enable register returns the enable state in bits 15:0. Bits 31:16 always read 0.
- R5: A read request (`bus_req` = 1, `bus_we` = 0) sampled at a clock edge produces `rd_valid` = 1 with `rd_data` from the following cycle. While `rd_valid` is 0, `rd_data` is 0.
- R6: A read of status register `g` returns the enable state of register `g` as it stood SYNC_STAGES cycles earlier (default 2). Bits 31:16 read 0. A status bit therefore rises only after its clock has been switched on.
- R7: `clk_en` changes only on the clock edge that samples a write to an enable register, and it reflects the new value from the next cycle.
- R8: A synchronous active-high reset loads the enable bits with RESET_EN. The status registers then read RESET_EN as well, with no settling delay.
- R9: Writes to an offset that is unmapped, out of range or not 4-byte aligned change nothing. Reads from such an offset return 0 with `rd_valid` = 1.
- R10: A write request never produces a read response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data: mask in 31:16, values in 15:0 |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data, 0 when not valid |
| clk_en | output | NUM_REGS*16 | Registered enable per module clock |

## Verification
The bench targets partial masks where the mask bits and data bits disagree. A design that ignored the mask would clear or set neighbouring clocks, which shows both on `clk_en` and in the readback. Back-to-back status reads follow an enable and a disable. A synchroniser that is one stage too short or too long would report the new state one read early or one read late. Writes and reads to an unaligned offset, to an index one past the last register and to a gap between the two regions would leave a mark on `clk_en` or return nonzero data if the decode were loose. A mid-run reset checks that enables and status return to the default together, rather than the status lagging behind.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
  localparam int GRP_W  = 16;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic en_hit;
    logic mon_hit;
  } hit_t;
endpackage

// File: rtl/cgb_addr_dec.sv
module cgb_addr_dec
  import cgb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 4,
  parameter int EN_BASE  = 'h600,
  parameter int MON_BASE = 'h800,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(4 * NUM_REGS);
  localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] MON_LO = ADDR_W'(MON_BASE);

  logic [ADDR_W-1:0] en_off;
  logic [ADDR_W-1:0] mon_off;

  // Offsets wrap when addr is below a base, so one compare covers both ends.
  always_comb begin
    en_off      = addr - EN_LO;
    mon_off     = addr - MON_LO;
    hit.en_hit  = (en_off < SPAN) && (en_off[1:0] == 2'b00);
    hit.mon_hit = (mon_off < SPAN) && (mon_off[1:0] == 2'b00);
    idx         = hit.en_hit ? en_off[IDX_W+1:2] : mon_off[IDX_W+1:2];
  end
endmodule

// File: rtl/cgb_en_reg.sv
module cgb_en_reg
  import cgb_pkg::*;
#(
  parameter logic [GRP_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [GRP_W-1:0]  q
);
  logic [GRP_W-1:0] mask;
  logic [GRP_W-1:0] val;

  always_comb begin
    mask = wdata[WORD_W-1:GRP_W];
    val  = wdata[GRP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else if (wr) q <= (q & ~mask) | (val & mask);
  end
endmodule

// File: rtl/cgb_mon_sync.sv
module cgb_mon_sync #(
  parameter int            W       = 64,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[s] <= RST_VAL;
      else st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import cgb_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGS    = 4,
  parameter int EN_BASE     = 'h600,
  parameter int MON_BASE    = 'h800,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_REGS*16-1:0] RESET_EN = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic                   rd_valid,
  output logic [31:0]            rd_data,
  output logic [NUM_REGS*16-1:0] clk_en
);
  localparam int NUM_CLK = NUM_REGS * GRP_W;
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  hit_t             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic [GRP_W-1:0] en_q [NUM_REGS];
  logic [NUM_CLK-1:0] mon_state;
  logic [WORD_W-1:0]  rd_next;

  cgb_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .EN_BASE(EN_BASE),
    .MON_BASE(MON_BASE), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .hit(dec_hit), .idx(dec_idx)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_grp
    logic wr_sel;
    assign wr_sel = bus_req && bus_we && dec_hit.en_hit && (dec_idx == IDX_W'(g));

    cgb_en_reg #(.RST_VAL(RESET_EN[g*GRP_W +: GRP_W])) u_reg (
      .clk(clk), .rst(rst), .wr(wr_sel), .wdata(bus_wdata), .q(en_q[g])
    );

    assign clk_en[g*GRP_W +: GRP_W] = en_q[g];
  end

  cgb_mon_sync #(.W(NUM_CLK), .STAGES(SYNC_STAGES), .RST_VAL(RESET_EN)) u_mon (
    .clk(clk), .rst(rst), .d(clk_en), .q(mon_state)
  );

  always_comb begin
    rd_next = '0;
    if (dec_hit.en_hit)
      rd_next[GRP_W-1:0] = en_q[dec_idx];
    else if (dec_hit.mon_hit)
      rd_next[GRP_W-1:0] = mon_state[int'(dec_idx)*GRP_W +: GRP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (bus_req && !bus_we) begin
      rd_valid <= 1'b1;
      rd_data  <= rd_next;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end
endmodule

// File: rtl/cgb_checker.sv
module cgb_checker #(
  parameter int NUM_CLK     = 64,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_req,
  input logic               bus_we,
  input logic               rd_valid,
  input logic [31:0]        rd_data,
  input logic [NUM_CLK-1:0] clk_en,
  input logic [NUM_CLK-1:0] mon_state
);
  logic [3:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 4'hF) age <= age + 4'd1;
  end

  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> $stable(clk_en));

  a_r6_status_lag: assert property (@(posedge clk) disable iff (rst)
    (int'(age) >= SYNC_STAGES) |-> (mon_state == $past(clk_en, SYNC_STAGES)));

  a_r5_read_answer: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> rd_valid);

  a_r10_no_write_answer: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !rd_valid);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[31:16] == 16'h0));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == 32'h0));
endmodule

bind clk_gate_bank cgb_checker #(
  .NUM_CLK(NUM_REGS*16), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_clk_gate_bank.sv
`timescale 1ns/1ps
module sim_clk_gate_bank;
  localparam int NR = 4;
  localparam int NC = NR * 16;
  localparam int S  = 2;
  localparam logic [NC-1:0] RST_EN = 64'h0001_0000_0000_8001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NC-1:0] clk_en;

  int checks = 0;
  int failures = 0;
  logic [NC-1:0] m_en;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  clk_gate_bank #(.NUM_REGS(NR), .SYNC_STAGES(S), .RESET_EN(RST_EN)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .clk_en(clk_en)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected word per read response.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 64'(rd_data), 64'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, 64'(rd_data), 64'(e));
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    model_read = 32'h0;
    if (a[1:0] == 2'b00 && a >= 12'h600 && a < 12'h600 + 4*NR)
      model_read = {16'h0, m_en[(int'(a - 12'h600) / 4) * 16 +: 16]};
    else if (a[1:0] == 2'b00 && a >= 12'h800 && a < 12'h800 + 4*NR)
      model_read = {16'h0, m_en[(int'(a - 12'h800) / 4) * 16 +: 16]};
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (a[1:0] == 2'b00 && a >= 12'h600 && a < 12'h600 + 4*NR) begin
      int g;
      g = int'(a - 12'h600) / 4;
      for (int b = 0; b < 16; b++)
        if (d[16+b]) m_en[g*16+b] = d[b];
    end
  endtask

  // Expected word pushed by the driver before the request goes out.
  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] old1;
    m_en = RST_EN;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset defaults on outputs and in both register views
    chk(clk_en === RST_EN, "R8 reset enables", clk_en, RST_EN);
    bus_rd(12'h600, 32'h0000_8001, "R8 reset enable reg0");
    bus_rd(12'h80C, 32'h0000_0001, "R8 reset status reg3");

    // R3/R7: set one bit; visible on clk_en the cycle after
    bus_wr(12'h600, 32'h0002_0002);
    chk(clk_en === m_en, "R7 R3 single bit on", clk_en, m_en);
    // R3: clear bits 0 and 1 through mask
    bus_wr(12'h600, 32'h0003_0000);
    chk(clk_en[15:0] === 16'h8000, "R3 masked clear", clk_en, 64'h8000);
    // R2: data without mask changes nothing
    bus_wr(12'h600, 32'h0000_FFFF);
    chk(clk_en === m_en, "R2 no mask no change", clk_en, m_en);
    // R2: mixed mask and data on reg2
    bus_wr(12'h608, 32'h00F0_FF5F);
    chk(clk_en[47:32] === 16'h0050, "R2 partial mask", 64'(clk_en[47:32]), 64'h0050);
    // R1: index mapping of reg3 and reg1
    bus_wr(12'h60C, 32'hFFFF_1234);
    chk(clk_en[63:48] === 16'h1234, "R1 reg3 to clk_en 63:48", 64'(clk_en[63:48]), 64'h1234);
    bus_wr(12'h604, 32'hFFFF_A5A4);
    chk(clk_en[31:16] === 16'hA5A4, "R1 reg1 to clk_en 31:16", 64'(clk_en[31:16]), 64'hA5A4);
    // R4/R1: readback of every enable register
    for (int g = 0; g < NR; g++) begin
      logic [11:0] a;
      a = 12'h600 + 12'(4*g);
      bus_rd(a, model_read(a), "R4 R1 enable readback");
    end
    idle(S + 2);
    for (int g = 0; g < NR; g++) begin
      logic [11:0] a;
      a = 12'h800 + 12'(4*g);
      bus_rd(a, model_read(a), "R6 R1 settled status");
    end

    // R6: status lag on enable, then on disable
    old1 = m_en[31:16];
    bus_wr(12'h604, 32'h0001_0001);
    for (int i = 0; i < S; i++) bus_rd(12'h804, {16'h0, old1}, "R6 status still old after on");
    bus_rd(12'h804, {16'h0, m_en[31:16]}, "R6 status new after on");
    old1 = m_en[31:16];
    bus_wr(12'h604, 32'h0004_0000);
    for (int i = 0; i < S; i++) bus_rd(12'h804, {16'h0, old1}, "R6 status still old after off");
    bus_rd(12'h804, {16'h0, m_en[31:16]}, "R6 status new after off");

    // R9: stray writes leave clk_en alone
    bus_wr(12'h700, 32'hFFFF_FFFF);
    chk(clk_en === m_en, "R9 gap write ignored", clk_en, m_en);
    bus_wr(12'h610, 32'hFFFF_FFFF);
    chk(clk_en === m_en, "R9 index past end ignored", clk_en, m_en);
    bus_wr(12'h602, 32'hFFFF_0000);
    chk(clk_en === m_en, "R9 unaligned write ignored", clk_en, m_en);
    bus_wr(12'h804, 32'hFFFF_0000);
    chk(clk_en === m_en, "R9 status write ignored", clk_en, m_en);
    bus_rd(12'h700, 32'h0, "R9 gap read zero");
    bus_rd(12'h610, 32'h0, "R9 past end read zero");
    bus_rd(12'h81C, 32'h0, "R9 status past end read zero");
    bus_rd(12'h602, 32'h0, "R9 unaligned read zero");
    idle(3);
    chk(exp_q.size() == 0, "R5 R10 every read answered once", 64'(exp_q.size()), 64'h0);

    // R8: reset mid-run
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    m_en = RST_EN;
    @(negedge clk);
    chk(clk_en === RST_EN, "R8 reset again", clk_en, RST_EN);
    bus_rd(12'h800, 32'h0000_8001, "R8 status at default at once");
    bus_rd(12'h604, 32'h0000_0000, "R8 reg1 default");
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule